// File: doc/BRIEF.md
# Four-Channel Converter Code Front End

This block is the digital side of a four-channel 12-bit converter. A host processor writes codes over a parallel bus that is either 12 or 8 bits wide. Each channel has two registers in series. The first is a staging register that the host writes one channel at a time. The second is a core register that feeds the converter core. A single commit strobe moves all four staging registers into their core registers in the same cycle, so the four outputs change together.

Codes are offset binary: 0x000 is negative full scale, 0x800 is zero, and 0xFFF is positive full scale less one step. Each core register holds its code in segmented form. The top three bits become a 7-bit thermometer field, and the nine low bits are kept as they are. A clear command, or reset, drives every core register to the zero code.

On an 8-bit bus the host loads a channel in two passes. The first pass is a wide write that sets the upper eight bits; the bus sits on the top data lines, so the upper eight bits arrive left-aligned. The second pass is a narrow write, which takes the four low bits from the top four data lines. For debug and checking, each channel also brings out the binary code it currently holds.

Top module: `qdac_front`

## Requirements
- R1: While `rst_n` is low, and after it returns high, every staging register and every core register holds 0x800. Each `seg_therm` field then reads 7'b0001111, each `low_bits` field reads 0, and each `code_view` field reads 0x800.
- R2: A write with `bus_wide`=1 loads all 12 bits of `data_in` unchanged into the staging register selected by `ch_addr` (0 to 3). The other three staging registers do not change.
- R3: A write with `bus_wide`=0 sets bits [3:0] of the selected staging register to `data_in[11:8]` and leaves bits [11:4] of that register unchanged.
- R4: A staging register is written only in a cycle where `cs` and `wr_load` are both 1. If either one is 0, no staging register changes.
- R5: A cycle with `wr_commit`=1, `xfer_req`=1 and `clr_req`=0 copies all four staging registers into their core registers together. The values copied are the ones the staging registers held before that edge.
- R6: A cycle with `wr_commit`=1 and `clr_req`=1 sets all four core registers to 0x800, whatever the value of `xfer_req`.
- R7: The thermometer field of each channel holds code[11:9] ones, filled from bit 0 upward with no gaps. `low_bits` equals code[8:0].
- R8: A core register changes only on a commit cycle (R5) or a clear cycle (R6). `xfer_req` or `clr_req` without `wr_commit` has no effect.
- R9: Each `code_view` field equals {number of ones in the thermometer field, `low_bits`}, the binary form of the core register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every control combination is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, modelling power-on reset |
| cs | input | 1 | Chip select for staging writes |
| wr_load | input | 1 | Strobe that writes a staging register |
| wr_commit | input | 1 | Strobe that qualifies transfer and clear |
| ch_addr | input | 2 | Selects which staging register is written |
| xfer_req | input | 1 | Requests a transfer of all staging registers into the core registers |
| clr_req | input | 1 | Requests a clear of all core registers to mid-scale |
| bus_wide | input | 1 | 1 selects a full 12-bit write, 0 selects a low-nibble write from the top data lines |
| data_in | input | 12 | Write data |
| seg_therm | output | 28 | Thermometer fields, channel n in bits [7n+6:7n] |
| low_bits | output | 36 | Nine low code bits, channel n in bits [9n+8:9n] |
| code_view | output | 48 | Binary form of each core register, channel n in bits [12n+11:12n] |

## Verification
The assertions check four things on every cycle. Each thermometer field has a legal shape. The debug code agrees with the segmented fields. Core registers hold between commands, and staging registers hold outside write cycles. A commit copies the staging values from before the edge, and a clear lands on 0x800.

Some behaviour only the bench's scenarios can show. These are the exact bit placement of narrow two-pass loading, channel address decoding across every code value, clear winning over transfer, and a write and a commit in the same cycle, where the commit moves the old value.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  parameter int CODE_W   = 12;
  parameter int SEG_W    = 3;
  parameter int NARROW_W = 8;
  localparam int THERM_W = (1 << SEG_W) - 1;
  localparam int LOW_W   = CODE_W - SEG_W;
  localparam int NIB_W   = CODE_W - NARROW_W;
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  function automatic logic [THERM_W-1:0] seg_encode(input logic [SEG_W-1:0] v);
    logic [THERM_W-1:0] t;
    for (int i = 0; i < THERM_W; i++) t[i] = (i < int'(v));
    return t;
  endfunction

  function automatic logic [SEG_W-1:0] seg_count(input logic [THERM_W-1:0] t);
    logic [SEG_W-1:0] n;
    n = '0;
    for (int i = 0; i < THERM_W; i++) n = n + SEG_W'(t[i]);
    return n;
  endfunction

  function automatic logic [CODE_W-1:0] narrow_merge(input logic [CODE_W-1:0] old,
                                                     input logic [CODE_W-1:0] din);
    return {old[CODE_W-1:NIB_W], din[CODE_W-1 -: NIB_W]};
  endfunction
endpackage

// File: rtl/qdac_stage_bank.sv
module qdac_stage_bank #(
  parameter int NCH    = 4,
  parameter int CODE_W = qdac_pkg::CODE_W,
  localparam int AW    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic              wide,
  input  logic [CODE_W-1:0] din,
  output logic [NCH*CODE_W-1:0] stage_flat
);
  import qdac_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] q;
    logic              hit;
    assign hit = wr_en && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= MID_CODE;
      else if (hit)    q <= wide ? din : narrow_merge(q, din);
    end
    assign stage_flat[g*CODE_W +: CODE_W] = q;
  end
endmodule

// File: rtl/qdac_core_bank.sv
module qdac_core_bank #(
  parameter int NCH    = 4,
  parameter int CODE_W = qdac_pkg::CODE_W,
  localparam int TW    = qdac_pkg::THERM_W,
  localparam int LW    = qdac_pkg::LOW_W,
  localparam int SW    = qdac_pkg::SEG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_all,
  input  logic                  clear_all,
  input  logic [NCH*CODE_W-1:0] src_flat,
  output logic [NCH*TW-1:0]     therm_flat,
  output logic [NCH*LW-1:0]     low_flat,
  output logic [NCH*CODE_W-1:0] code_flat
);
  import qdac_pkg::*;
  localparam logic [TW-1:0] MID_THERM = seg_encode(MID_CODE[CODE_W-1 -: SW]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [TW-1:0]     therm_q;
    logic [LW-1:0]     low_q;
    logic [CODE_W-1:0] src;
    assign src = src_flat[g*CODE_W +: CODE_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        therm_q <= MID_THERM;
        low_q   <= MID_CODE[LW-1:0];
      end else if (clear_all) begin
        therm_q <= MID_THERM;
        low_q   <= MID_CODE[LW-1:0];
      end else if (load_all) begin
        therm_q <= seg_encode(src[CODE_W-1 -: SW]);
        low_q   <= src[LW-1:0];
      end
    end
    assign therm_flat[g*TW +: TW]     = therm_q;
    assign low_flat[g*LW +: LW]       = low_q;
    assign code_flat[g*CODE_W +: CODE_W] = {seg_count(therm_q), low_q};
  end
endmodule

// File: rtl/qdac_front.sv
module qdac_front #(
  parameter int NCH    = 4,
  parameter int CODE_W = qdac_pkg::CODE_W,
  localparam int AW    = $clog2(NCH),
  localparam int TW    = qdac_pkg::THERM_W,
  localparam int LW    = qdac_pkg::LOW_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  wr_load,
  input  logic                  wr_commit,
  input  logic [AW-1:0]         ch_addr,
  input  logic                  xfer_req,
  input  logic                  clr_req,
  input  logic                  bus_wide,
  input  logic [CODE_W-1:0]     data_in,
  output logic [NCH*TW-1:0]     seg_therm,
  output logic [NCH*LW-1:0]     low_bits,
  output logic [NCH*CODE_W-1:0] code_view
);
  logic                  stage_we;
  logic                  commit_clear;
  logic                  commit_xfer;
  logic [NCH*CODE_W-1:0] stage_flat;

  assign stage_we     = cs && wr_load;
  assign commit_clear = wr_commit && clr_req;
  assign commit_xfer  = wr_commit && xfer_req && !clr_req;

  qdac_stage_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(stage_we), .addr(ch_addr),
    .wide(bus_wide), .din(data_in), .stage_flat(stage_flat)
  );

  qdac_core_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load_all(commit_xfer), .clear_all(commit_clear),
    .src_flat(stage_flat), .therm_flat(seg_therm), .low_flat(low_bits),
    .code_flat(code_view)
  );
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  parameter int TW     = 7,
  parameter int LW     = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs,
  input logic                  wr_load,
  input logic                  wr_commit,
  input logic                  xfer_req,
  input logic                  clr_req,
  input logic [NCH*CODE_W-1:0] stage_flat,
  input logic [NCH*TW-1:0]     seg_therm,
  input logic [NCH*LW-1:0]     low_bits,
  input logic [NCH*CODE_W-1:0] code_view
);
  localparam int SW = CODE_W - LW;

  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr_load) |=> $stable(stage_flat));

  p_core_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_commit && (xfer_req || clr_req)) |=> $stable(code_view));

  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && xfer_req && !clr_req) |=> (code_view == $past(stage_flat)));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [TW-1:0] t;
    assign t = seg_therm[g*TW +: TW];

    p_clear_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && clr_req) |=> (code_view[g*CODE_W +: CODE_W] == {1'b1, {(CODE_W-1){1'b0}}}));

    p_therm_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((t & (t + TW'(1))) == '0));

    p_view_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (code_view[g*CODE_W +: CODE_W] ==
       {SW'($countones(t)), low_bits[g*LW +: LW]}));
  end
endmodule

bind qdac_front qdac_front_chk #(.NCH(NCH), .CODE_W(CODE_W), .TW(TW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr_load(wr_load), .wr_commit(wr_commit),
  .xfer_req(xfer_req), .clr_req(clr_req), .stage_flat(stage_flat),
  .seg_therm(seg_therm), .low_bits(low_bits), .code_view(code_view)
);

// File: tb/tb_qdac_front.sv
module tb_qdac_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 0, wr_load = 0, wr_commit = 0, xfer_req = 0, clr_req = 0, bus_wide = 1;
  logic [1:0]  ch_addr = '0;
  logic [11:0] data_in = '0;
  logic [27:0] seg_therm;
  logic [35:0] low_bits;
  logic [47:0] code_view;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_stage [4];
  logic [11:0] m_core  [4];

  always #2.5 clk = ~clk;

  qdac_front dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_load(wr_load), .wr_commit(wr_commit),
    .ch_addr(ch_addr), .xfer_req(xfer_req), .clr_req(clr_req), .bus_wide(bus_wide),
    .data_in(data_in), .seg_therm(seg_therm), .low_bits(low_bits), .code_view(code_view)
  );

  function automatic logic [6:0] exp_therm(input logic [11:0] c);
    logic [6:0] t;
    int level;
    level = int'(c) / 512;
    t = '0;
    for (int b = 0; b < 7; b++) if (b < level) t[b] = 1'b1;
    return t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, 32'(code_view[c*12 +: 12]), 32'(m_core[c]));
      chk({req, "/R7 therm"}, 32'(seg_therm[c*7 +: 7]), 32'(exp_therm(m_core[c])));
      chk({req, "/R7 low"}, 32'(low_bits[c*9 +: 9]), 32'(m_core[c] % 512));
    end
  endtask

  // Called at a falling edge; drives one cycle and tracks the model.
  task automatic cyc(input logic c, w1, w2, x, cl, wd, input logic [1:0] a,
                     input logic [11:0] d);
    cs = c; wr_load = w1; wr_commit = w2; xfer_req = x; clr_req = cl;
    bus_wide = wd; ch_addr = a; data_in = d;
    @(posedge clk);
    if (w2 && cl)     for (int k = 0; k < 4; k++) m_core[k] = 12'h800;
    else if (w2 && x) for (int k = 0; k < 4; k++) m_core[k] = m_stage[k];
    if (c && w1) m_stage[a] = wd ? d : {m_stage[a][11:4], d[11:8]};
    @(negedge clk);
    cs = 0; wr_load = 0; wr_commit = 0; xfer_req = 0; clr_req = 0; bus_wide = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d, input logic wd);
    cyc(1, 1, 0, 0, 0, wd, a, d);
  endtask

  task automatic commit();
    cyc(0, 0, 1, 1, 0, 1, 2'd0, 12'h000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_stage[k] = 12'h800; m_core[k] = 12'h800; end
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");
    commit();
    check_all("R1 staging reset value");

    // R2 / R7 / R9: every code value through a rotating channel
    for (int v = 0; v < 4096; v++) begin
      wr(2'(v % 4), 12'(v), 1'b1);
      commit();
      check_all("R2 wide write");
    end

    // R8: staging write alone does not reach the core
    wr(2'd0, 12'h123, 1'b1);
    check_all("R8 hold without commit");
    cyc(0, 0, 0, 1, 0, 1, 2'd0, 12'h0);
    check_all("R8 xfer without strobe");
    cyc(0, 0, 0, 0, 1, 1, 2'd0, 12'h0);
    check_all("R8 clr without strobe");

    // R4: half-qualified writes ignored
    cyc(0, 1, 0, 0, 0, 1, 2'd1, 12'hFFF);
    cyc(1, 0, 0, 0, 0, 1, 2'd2, 12'hFFF);
    commit();
    check_all("R4 unqualified write");

    // R3: two-pass narrow loading on every channel
    for (int c = 0; c < 4; c++) begin
      for (int n = 0; n < 16; n++) begin
        wr(2'(c), 12'(16'hAB0 + 16'(c * 16)), 1'b1);
        wr(2'(c), {4'(n), 8'hFF}, 1'b0);
        commit();
        check_all("R3 narrow write");
      end
    end

    // R5: write and commit in the same cycle moves the old value
    wr(2'd3, 12'h456, 1'b1);
    cyc(1, 1, 1, 1, 0, 1, 2'd3, 12'h789);
    check_all("R5 same-cycle old value");
    commit();
    check_all("R5 later commit");

    // R6: clear, and clear winning over transfer
    cyc(0, 0, 1, 0, 1, 1, 2'd0, 12'h0);
    check_all("R6 clear");
    commit();
    check_all("R6 reload");
    cyc(0, 0, 1, 1, 1, 1, 2'd0, 12'h0);
    check_all("R6 clear priority");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule